// File: doc/BRIEF.md
# Two-Bin Look-Ahead Binary Arithmetic Decoder

This block is the bin-decoding engine of a context-adaptive binary arithmetic decoder. It holds the arithmetic state, a 9-bit interval width (range) and a 9-bit code value (offset), and on each valid cycle it runs one of three engines: context-driven decision, equiprobable bypass, or terminate. A decision uses a context made of a 6-bit probability state and a most-probable-symbol (MPS) bit, and returns the updated context together with the bin.

The caller always supplies two contexts. In decision mode, with pairing enabled, the block checks whether the first bin went down the MPS path and left a range of at least 256. If both hold, a second decision bin is decoded in the same cycle with the second context. If either fails, the cycle yields one bin and takes no more time than a single-bin engine would. The bitstream arrives as a 9-bit look-ahead window, and the block reports each cycle how many window bits it consumed, so the feeder can advance.

Top module: `twoBinDecoder`

## Requirements
- R1: Reset leaves range = 510 and offset = 0. An `initPulse` takes priority over everything else: it loads range = 510 and offset = `bitWin`, reports `shiftCnt` = 9 and `binCount` = 0.
- R2: Decision (mode 0), MPS path: with rLps = lps(state, range[7:6]) and rMps = range − rLps, if offset < rMps then bin = MPS and range = rMps. The state advances by one, except that states 62 and 63 hold.
- R3: Decision, LPS path: if offset ≥ rMps then bin = !MPS, offset −= rMps and range = rLps. The new state is s − ((s+3)>>2), and the MPS bit flips when the old state is 0.
- R4: The LPS width is computed as follows. Let w(0) = 256 and w(s+1) = (w(s)·243)>>8. Then lps(s,q) = max(6, (w(s)·(4+q))>>3).
- R5: After any operation, range is doubled until it is at least 256. Each doubling shifts into the offset the next window bit, starting at `bitWin[8]`. `shiftCnt` equals the number of doublings and never exceeds 8.
- R6: When `pairEn` is set in decision mode, the first bin is MPS and rMps ≥ 256, a second bin is decoded with context B using range rMps and the unchanged offset. Then `binCount` = 2, `bin1` and context B are updated, and only the second bin renormalizes.
- R7: If the pairing condition fails, exactly one bin is produced and context B passes through unchanged.
- R8: Bypass (mode 1) forms v = 2·offset + `bitWin[8]`. The bin is 1 when v ≥ range, and in that case v −= range. The result becomes the offset, with `shiftCnt` = 1.
- R9: Terminate (mode 2) reduces range by 2. If offset ≥ the reduced range, the bin is 1, `termEnd` is raised, offset −= reduced range and range = 2. Otherwise the bin is 0. Either way the result is renormalized.
- R10: With `valid` low or mode 3, the operation has no effect: `binCount` = 0, `shiftCnt` = 0, contexts pass through and range and offset hold.
- R11: The offset stays strictly below the range at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| initPulse | input | 1 | Load arithmetic state from the window |
| valid | input | 1 | Perform the selected operation this cycle |
| mode | input | 2 | 0 decision, 1 bypass, 2 terminate, 3 idle |
| pairEn | input | 1 | Allow a second decision bin this cycle |
| bitWin | input | 9 | Next stream bits, bit 8 consumed first |
| ctxAState | input | 6 | Probability state of the first context |
| ctxAMps | input | 1 | MPS bit of the first context |
| ctxBState | input | 6 | Probability state of the second context |
| ctxBMps | input | 1 | MPS bit of the second context |
| binCount | output | 2 | Bins produced this cycle (0, 1 or 2) |
| bin0 | output | 1 | First decoded bin |
| bin1 | output | 1 | Second decoded bin |
| ctxAStateOut | output | 6 | Updated state of the first context |
| ctxAMpsOut | output | 1 | Updated MPS of the first context |
| ctxBStateOut | output | 6 | Updated state of the second context |
| ctxBMpsOut | output | 1 | Updated MPS of the second context |
| shiftCnt | output | 4 | Window bits consumed this cycle |
| termEnd | output | 1 | Terminate bin decoded as 1 |

## Verification
The case hardest to reach from the ports is a first bin on the MPS path whose remaining range falls below 256. Here the pairing must be refused even though no LPS occurred. The range only gets narrow enough after an earlier LPS. So the stimulus forces a chosen initial offset into the bit stream: it loads 300, takes an LPS from state 0 that leaves a range of 448, and then issues a paired decision whose MPS width is 224. The LPS flip at state 0, state saturation, the terminate hit, and a long mixed run driven by a reference model cover the remaining paths.

// File: rtl/twoBinPkg.sv
package twoBinPkg;
  localparam int STATE_W    = 6;
  localparam int RANGE_W    = 9;
  localparam int WIN_W      = 9;
  localparam int SHIFT_W    = 4;
  localparam int LANES      = 2;
  localparam int QUARTERS   = 4;
  localparam int NUM_STATES = 1 << STATE_W;
  localparam int RANGE_INIT = 510;
  localparam int MIN_LPS    = 6;
  localparam int DECAY_NUM  = 243;

  typedef enum logic [1:0] {
    MODE_DEC  = 2'd0,
    MODE_BYP  = 2'd1,
    MODE_TERM = 2'd2,
    MODE_IDLE = 2'd3
  } modeT;

  typedef struct packed {
    logic [STATE_W-1:0] state;
    logic               mps;
  } ctxT;

  typedef struct packed {
    logic doInit;
    logic doDec;
    logic doPair;
    logic doByp;
    logic doTerm;
  } strobeT;

  // probability weight: geometric decay from 256, integer truncated per step
  function automatic int lpsWeight(int s);
    int w;
    w = 256;
    for (int i = 0; i < s; i++) w = (w * DECAY_NUM) >> 8;
    return w;
  endfunction

  function automatic int lpsRange(int s, int q);
    int v;
    v = (lpsWeight(s) * (4 + q)) >> 3;
    if (v < MIN_LPS) v = MIN_LPS;
    return v;
  endfunction
endpackage

// File: rtl/binDecideSlice.sv
module binDecideSlice
  import twoBinPkg::*;
(
  input  logic [RANGE_W-1:0] rangeIn,
  input  logic [RANGE_W-1:0] offsetIn,
  input  ctxT                ctxIn,
  output logic               binOut,
  output logic               isLps,
  output logic [RANGE_W-1:0] rangeOut,
  output logic [RANGE_W-1:0] offsetOut,
  output ctxT                ctxOut
);
  localparam int Q_MSB = RANGE_W - 2;

  logic [7:0] lpsRom [NUM_STATES][QUARTERS];

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_state
    for (genvar q = 0; q < QUARTERS; q++) begin : g_quarter
      assign lpsRom[s][q] = 8'(lpsRange(s, q));
    end
  end

  logic [7:0]         rLps;
  logic [RANGE_W-1:0] rMps;
  logic [STATE_W:0]   dropStep;

  always_comb begin
    rLps     = lpsRom[ctxIn.state][rangeIn[Q_MSB -: 2]];
    rMps     = rangeIn - RANGE_W'(rLps);
    isLps    = offsetIn >= rMps;
    dropStep = ({1'b0, ctxIn.state} + (STATE_W+1)'(3)) >> 2;
    ctxOut   = ctxIn;
    if (isLps) begin
      binOut       = ~ctxIn.mps;
      rangeOut     = RANGE_W'(rLps);
      offsetOut    = offsetIn - rMps;
      ctxOut.state = ctxIn.state - STATE_W'(dropStep);
      if (ctxIn.state == '0) ctxOut.mps = ~ctxIn.mps;
    end else begin
      binOut    = ctxIn.mps;
      rangeOut  = rMps;
      offsetOut = offsetIn;
      if (ctxIn.state < STATE_W'(NUM_STATES - 2)) ctxOut.state = ctxIn.state + 1'b1;
    end
  end
endmodule

// File: rtl/renormShifter.sv
module renormShifter
  import twoBinPkg::*;
(
  input  logic [RANGE_W-1:0] rangeIn,
  input  logic [RANGE_W-1:0] offsetIn,
  input  logic [WIN_W-1:0]   win,
  output logic [RANGE_W-1:0] rangeOut,
  output logic [RANGE_W-1:0] offsetOut,
  output logic [SHIFT_W-1:0] shift
);
  logic [SHIFT_W-1:0] msb;

  always_comb begin
    msb = '0;
    for (int i = 0; i < RANGE_W; i++) begin
      if (rangeIn[i]) msb = SHIFT_W'(i);
    end
    shift     = SHIFT_W'(RANGE_W - 1) - msb;
    rangeOut  = rangeIn << shift;
    offsetOut = RANGE_W'(({offsetIn, win} << shift) >> WIN_W);
  end
endmodule

// File: rtl/twoBinCtrl.sv
module twoBinCtrl
  import twoBinPkg::*;
(
  input  logic       initPulse,
  input  logic       valid,
  input  logic [1:0] mode,
  input  logic       pairEn,
  input  logic       firstMpsWide,
  output strobeT     stb
);
  always_comb begin
    stb = '0;
    if (initPulse) begin
      stb.doInit = 1'b1;
    end else if (valid) begin
      case (modeT'(mode))
        MODE_DEC: begin
          stb.doDec  = 1'b1;
          stb.doPair = pairEn && firstMpsWide;
        end
        MODE_BYP:  stb.doByp  = 1'b1;
        MODE_TERM: stb.doTerm = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/twoBinDatapath.sv
module twoBinDatapath
  import twoBinPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             stb,
  input  logic [WIN_W-1:0]   bitWin,
  input  ctxT                ctxA,
  input  ctxT                ctxB,
  output logic               firstMpsWide,
  output logic [1:0]         binCount,
  output logic               bin0,
  output logic               bin1,
  output ctxT                ctxAOut,
  output ctxT                ctxBOut,
  output logic [SHIFT_W-1:0] shiftCnt,
  output logic               termEnd,
  output logic [RANGE_W-1:0] rangeQ,
  output logic [RANGE_W-1:0] offsetQ
);
  logic [RANGE_W-1:0] laneRange [LANES+1];
  logic [RANGE_W-1:0] laneOff   [LANES+1];
  ctxT                laneCtxIn [LANES];
  ctxT                laneCtxOut[LANES];
  logic               laneBin   [LANES];
  logic               laneLps   [LANES];

  assign laneRange[0] = rangeQ;
  assign laneOff[0]   = offsetQ;
  assign laneCtxIn[0] = ctxA;
  assign laneCtxIn[1] = ctxB;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    binDecideSlice u_slice (
      .rangeIn  (laneRange[i]),
      .offsetIn (laneOff[i]),
      .ctxIn    (laneCtxIn[i]),
      .binOut   (laneBin[i]),
      .isLps    (laneLps[i]),
      .rangeOut (laneRange[i+1]),
      .offsetOut(laneOff[i+1]),
      .ctxOut   (laneCtxOut[i])
    );
  end

  // second lane is usable only if lane 0 stayed on MPS with range >= 256
  assign firstMpsWide = !laneLps[0] && laneRange[1][RANGE_W-1];

  logic [RANGE_W-1:0] termRange;
  logic               termHit;
  logic [RANGE_W:0]   bypVal;
  logic               bypBin;
  logic [RANGE_W-1:0] bypOff;

  assign termRange = rangeQ - RANGE_W'(2);
  assign termHit   = offsetQ >= termRange;
  assign bypVal    = {offsetQ, bitWin[WIN_W-1]};
  assign bypBin    = bypVal >= {1'b0, rangeQ};
  assign bypOff    = bypBin ? RANGE_W'(bypVal - {1'b0, rangeQ}) : RANGE_W'(bypVal);

  logic [RANGE_W-1:0] nrmRangeIn, nrmOffIn, nrmRange, nrmOff;
  logic [SHIFT_W-1:0] nrmShift;

  always_comb begin
    if (stb.doTerm) begin
      nrmRangeIn = termHit ? RANGE_W'(2) : termRange;
      nrmOffIn   = termHit ? offsetQ - termRange : offsetQ;
    end else if (stb.doPair) begin
      nrmRangeIn = laneRange[2];
      nrmOffIn   = laneOff[2];
    end else begin
      nrmRangeIn = laneRange[1];
      nrmOffIn   = laneOff[1];
    end
  end

  renormShifter u_renorm (
    .rangeIn  (nrmRangeIn),
    .offsetIn (nrmOffIn),
    .win      (bitWin),
    .rangeOut (nrmRange),
    .offsetOut(nrmOff),
    .shift    (nrmShift)
  );

  logic [RANGE_W-1:0] rangeD, offsetD;

  always_comb begin
    binCount = 2'd0;
    bin0     = 1'b0;
    bin1     = 1'b0;
    ctxAOut  = ctxA;
    ctxBOut  = ctxB;
    shiftCnt = '0;
    termEnd  = 1'b0;
    rangeD   = rangeQ;
    offsetD  = offsetQ;
    if (stb.doInit) begin
      rangeD   = RANGE_W'(RANGE_INIT);
      offsetD  = RANGE_W'(bitWin);
      shiftCnt = SHIFT_W'(WIN_W);
    end else if (stb.doDec) begin
      binCount = stb.doPair ? 2'd2 : 2'd1;
      bin0     = laneBin[0];
      ctxAOut  = laneCtxOut[0];
      if (stb.doPair) begin
        bin1    = laneBin[1];
        ctxBOut = laneCtxOut[1];
      end
      rangeD   = nrmRange;
      offsetD  = nrmOff;
      shiftCnt = nrmShift;
    end else if (stb.doByp) begin
      binCount = 2'd1;
      bin0     = bypBin;
      offsetD  = bypOff;
      shiftCnt = SHIFT_W'(1);
    end else if (stb.doTerm) begin
      binCount = 2'd1;
      bin0     = termHit;
      termEnd  = termHit;
      rangeD   = nrmRange;
      offsetD  = nrmOff;
      shiftCnt = nrmShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeQ  <= RANGE_W'(RANGE_INIT);
      offsetQ <= '0;
    end else begin
      rangeQ  <= rangeD;
      offsetQ <= offsetD;
    end
  end
endmodule

// File: rtl/twoBinDecoder.sv
module twoBinDecoder
  import twoBinPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               initPulse,
  input  logic               valid,
  input  logic [1:0]         mode,
  input  logic               pairEn,
  input  logic [WIN_W-1:0]   bitWin,
  input  logic [STATE_W-1:0] ctxAState,
  input  logic               ctxAMps,
  input  logic [STATE_W-1:0] ctxBState,
  input  logic               ctxBMps,
  output logic [1:0]         binCount,
  output logic               bin0,
  output logic               bin1,
  output logic [STATE_W-1:0] ctxAStateOut,
  output logic               ctxAMpsOut,
  output logic [STATE_W-1:0] ctxBStateOut,
  output logic               ctxBMpsOut,
  output logic [SHIFT_W-1:0] shiftCnt,
  output logic               termEnd
);
  strobeT             stb;
  ctxT                ctxA, ctxB, ctxAOut, ctxBOut;
  logic               firstMpsWide;
  logic [RANGE_W-1:0] rangeQ, offsetQ;

  assign ctxA = {ctxAState, ctxAMps};
  assign ctxB = {ctxBState, ctxBMps};
  assign {ctxAStateOut, ctxAMpsOut} = ctxAOut;
  assign {ctxBStateOut, ctxBMpsOut} = ctxBOut;

  twoBinCtrl u_ctrl (
    .initPulse   (initPulse),
    .valid       (valid),
    .mode        (mode),
    .pairEn      (pairEn),
    .firstMpsWide(firstMpsWide),
    .stb         (stb)
  );

  twoBinDatapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .bitWin      (bitWin),
    .ctxA        (ctxA),
    .ctxB        (ctxB),
    .firstMpsWide(firstMpsWide),
    .binCount    (binCount),
    .bin0        (bin0),
    .bin1        (bin1),
    .ctxAOut     (ctxAOut),
    .ctxBOut     (ctxBOut),
    .shiftCnt    (shiftCnt),
    .termEnd     (termEnd),
    .rangeQ      (rangeQ),
    .offsetQ     (offsetQ)
  );
endmodule

// File: rtl/twoBinChecker.sv
module twoBinChecker
  import twoBinPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               initPulse,
  input logic               valid,
  input logic [1:0]         mode,
  input logic               pairEn,
  input logic [1:0]         binCount,
  input logic [SHIFT_W-1:0] shiftCnt,
  input logic [RANGE_W-1:0] rangeQ,
  input logic [RANGE_W-1:0] offsetQ
);
  logic idleOp;
  assign idleOp = !initPulse && (!valid || mode == 2'd3);

  p_init_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |=> rangeQ == RANGE_W'(RANGE_INIT));

  p_init_report_r1: assert property (@(posedge clk) disable iff (!rstN)
    initPulse |-> shiftCnt == SHIFT_W'(WIN_W) && binCount == 2'd0);

  p_range_norm_r5: assert property (@(posedge clk) disable iff (!rstN)
    rangeQ[RANGE_W-1]);

  p_shift_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    !initPulse |-> shiftCnt <= SHIFT_W'(8));

  p_pair_dec_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    binCount == 2'd2 |-> valid && mode == 2'd0 && pairEn && !initPulse);

  p_bypass_one_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!initPulse && valid && mode == 2'd1) |-> shiftCnt == SHIFT_W'(1) && binCount == 2'd1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    idleOp |-> binCount == 2'd0 && shiftCnt == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    idleOp |=> $stable(rangeQ) && $stable(offsetQ));

  p_offset_below_r11: assert property (@(posedge clk) disable iff (!rstN)
    offsetQ < rangeQ);
endmodule

bind twoBinDecoder twoBinChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .initPulse(initPulse),
  .valid    (valid),
  .mode     (mode),
  .pairEn   (pairEn),
  .binCount (binCount),
  .shiftCnt (shiftCnt),
  .rangeQ   (rangeQ),
  .offsetQ  (offsetQ)
);

// File: tb/twoBinDecoder_tb.sv
module twoBinDecoder_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initPulse = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       pairEn = 1'b0;
  logic [8:0] bitWin = '0;
  logic [5:0] ctxAState = '0;
  logic       ctxAMps = 1'b0;
  logic [5:0] ctxBState = '0;
  logic       ctxBMps = 1'b0;
  logic [1:0] binCount;
  logic       bin0, bin1;
  logic [5:0] ctxAStateOut, ctxBStateOut;
  logic       ctxAMpsOut, ctxBMpsOut;
  logic [3:0] shiftCnt;
  logic       termEnd;

  int checks = 0;
  int fails = 0;
  int mRange = 510;
  int mOffset = 0;
  int ptr = 0;
  bit stream [8192];

  always #10 clk = ~clk;

  twoBinDecoder u_dut (
    .clk(clk), .rstN(rstN), .initPulse(initPulse), .valid(valid), .mode(mode),
    .pairEn(pairEn), .bitWin(bitWin), .ctxAState(ctxAState), .ctxAMps(ctxAMps),
    .ctxBState(ctxBState), .ctxBMps(ctxBMps), .binCount(binCount), .bin0(bin0),
    .bin1(bin1), .ctxAStateOut(ctxAStateOut), .ctxAMpsOut(ctxAMpsOut),
    .ctxBStateOut(ctxBStateOut), .ctxBMpsOut(ctxBMpsOut), .shiftCnt(shiftCnt),
    .termEnd(termEnd)
  );

  function automatic int lpsR(int s, int q);
    int w = 256;
    int v;
    for (int i = 0; i < s; i++) w = (w * 243) >> 8;
    v = (w * (4 + q)) >> 3;
    return (v < 6) ? 6 : v;
  endfunction

  task automatic mDecide(inout int r, inout int o, inout int s, inout bit m,
                         output bit b, output bit lps);
    int rl = lpsR(s, (r >> 6) & 3);
    int rm = r - rl;
    if (o >= rm) begin
      lps = 1'b1; b = !m; o = o - rm; r = rl;
      if (s == 0) m = !m;
      s = s - ((s + 3) >> 2);
    end else begin
      lps = 1'b0; b = m; r = rm;
      if (s < 62) s = s + 1;
    end
  endtask

  task automatic mRenorm(inout int r, inout int o, output int n);
    n = 0;
    while (r < 256) begin
      r = r * 2;
      o = o * 2 + int'(stream[ptr + n]);
      n++;
    end
  endtask

  task automatic setStream(input int pos, input int val);
    for (int k = 0; k < 9; k++) stream[pos + k] = bit'((val >> (8 - k)) & 1);
  endtask

  task automatic runOp(input bit ini, input bit vld, input int md, input bit pe,
                       input int sa, input bit ma, input int sb, input bit mb,
                       input string tag);
    int r = mRange;
    int o = mOffset;
    int aS = sa;
    int bS = sb;
    bit aM = ma;
    bit bM = mb;
    int eBc = 0;
    int eSh = 0;
    bit eB0 = 0;
    bit eB1 = 0;
    bit eTe = 0;
    bit l0, l1;
    int win = 0;
    logic [22:0] expv, actv;
    for (int k = 0; k < 9; k++) win = win * 2 + int'(stream[ptr + k]);
    @(negedge clk);
    initPulse = ini; valid = vld; mode = md[1:0]; pairEn = pe;
    ctxAState = sa[5:0]; ctxAMps = ma; ctxBState = sb[5:0]; ctxBMps = mb;
    bitWin = win[8:0];
    if (ini) begin
      r = 510; o = win; eSh = 9;
    end else if (vld) begin
      case (md)
        0: begin
          mDecide(r, o, aS, aM, eB0, l0);
          eBc = 1;
          if (pe && !l0 && r >= 256) begin
            mDecide(r, o, bS, bM, eB1, l1);
            eBc = 2;
          end
          mRenorm(r, o, eSh);
        end
        1: begin
          o = o * 2 + int'(stream[ptr]);
          if (o >= r) begin eB0 = 1; o = o - r; end
          eBc = 1; eSh = 1;
        end
        2: begin
          r = r - 2; eBc = 1;
          if (o >= r) begin eB0 = 1; eTe = 1; o = o - r; r = 2; end
          mRenorm(r, o, eSh);
        end
        default: ;
      endcase
    end
    expv = {eBc[1:0], eB0, eB1, aS[5:0], aM, bS[5:0], bM, eSh[3:0], eTe};
    #5;
    actv = {binCount, bin0, bin1, ctxAStateOut, ctxAMpsOut, ctxBStateOut, ctxBMpsOut,
            shiftCnt, termEnd};
    checks++;
    if (actv !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
    @(posedge clk);
    mRange = r; mOffset = o; ptr = ptr + eSh;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mRange = 510; mOffset = 0;
    runOp(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset quiet outputs");
    runOp(0, 1, 0, 0, 0, 0, 0, 0, "R1 reset range 510 offset 0");
  endtask

  task automatic tInit();
    setStream(ptr, 123);
    runOp(1, 1, 0, 1, 7, 1, 3, 0, "R1 init load");
    runOp(0, 1, 0, 0, 9, 1, 0, 0, "R1 after init");
  endtask

  task automatic tMps();
    setStream(ptr, 0);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init zero");
    runOp(0, 1, 0, 0, 10, 1, 0, 0, "R2 mps path");
    runOp(0, 1, 0, 0, 62, 0, 0, 0, "R2 saturate 62");
    runOp(0, 1, 0, 0, 63, 1, 0, 0, "R2 saturate 63");
  endtask

  task automatic tLps();
    setStream(ptr, 500);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init 500");
    runOp(0, 1, 0, 0, 0, 1, 0, 0, "R3 lps flip at state 0");
    setStream(ptr, 505);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init 505");
    runOp(0, 1, 0, 0, 40, 0, 0, 0, "R4 R5 lps narrow range renorm");
  endtask

  task automatic tPair();
    setStream(ptr, 0);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init zero");
    runOp(0, 1, 0, 1, 5, 1, 5, 0, "R6 pair decode");
    runOp(0, 1, 0, 1, 20, 0, 50, 1, "R6 pair second");
  endtask

  task automatic tFallback();
    setStream(ptr, 500);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init 500");
    runOp(0, 1, 0, 1, 0, 1, 12, 1, "R7 lps first single bin");
    setStream(ptr, 300);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init 300");
    runOp(0, 1, 0, 0, 0, 1, 0, 0, "R3 lps to range 448");
    runOp(0, 1, 0, 1, 0, 1, 33, 0, "R7 mps but narrow range");
  endtask

  task automatic tBypass();
    for (int n = 0; n < 6; n++) runOp(0, 1, 1, 0, n, 0, n, 1, "R8 bypass");
  endtask

  task automatic tTerm();
    setStream(ptr, 0);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init zero");
    runOp(0, 1, 2, 0, 3, 0, 4, 0, "R9 terminate zero");
    setStream(ptr, 509);
    runOp(1, 0, 0, 0, 0, 0, 0, 0, "R1 init 509");
    runOp(0, 1, 2, 0, 3, 0, 4, 0, "R9 terminate hit");
  endtask

  task automatic tIdle();
    runOp(0, 0, 0, 1, 14, 1, 15, 1, "R10 valid low");
    runOp(0, 1, 3, 1, 14, 1, 15, 1, "R10 mode 3");
    runOp(0, 1, 0, 1, 14, 1, 15, 1, "R10 state held");
  endtask

  task automatic tRandom();
    for (int n = 0; n < 300; n++) begin
      int md = ($urandom_range(0, 9) < 6) ? 0 : int'($urandom_range(1, 3));
      runOp(0, 1, md, bit'($urandom_range(0, 1)), int'($urandom_range(0, 63)),
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 63)),
            bit'($urandom_range(0, 1)), "R5 R6 R7 R11 mixed");
    end
  endtask

  initial begin
    int lf = 16'hACE1;
    for (int i = 0; i < 8192; i++) begin
      lf = ((lf >> 1) ^ ((lf & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      stream[i] = bit'(lf & 1);
    end
    tReset();
    tInit();
    tMps();
    tLps();
    tPair();
    tFallback();
    tBypass();
    tTerm();
    tIdle();
    tRandom();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule